// File: doc/BRIEF.md
# Key Matrix Scanner with Debounce and Interrupt

This block reads a small matrix of key switches by reusing the cathode timeslots of a multiplexed LED display as scan strobes. While each digit slot is active, two active-low return lines are sampled. Each return line carries one key per digit, so four digits and two returns give eight keys. The display multiplexer supplies the current digit, a one-cycle slot strobe and the scan limit. The register block supplies the port configuration and a read-clear strobe.

Keys are debounced over a long scan cycle made of CYC_MUX multiplex sweeps, and each cycle holds two tests. The first test is taken in the last sweep of the first half and the second test in the last sweep of the cycle. A key is reported once per press, with n-key rollover. The report goes into an accumulating register that is cleared on read, and it can raise an interrupt. The same port configuration selects what a shared output pin carries: a fixed logic level, the interrupt in either polarity, or the segment driver.

Top module: `kscan_top`

## Requirements
- R1: After reset, key_prs, key_deb and irq_flag are all zero and the sweep count is zero.
- R2: Key d (0..N_DIG-1) reads ret_n[0] and key N_DIG+d reads ret_n[1] on a slot_vld cycle with dig_idx=d, where low means pressed. key_prs changes only at the end of a test sweep, and then holds the samples of that sweep.
- R3: A multiplex sweep ends on a slot_vld cycle with dig_idx equal to scan_lim. Sweeps are counted from reset modulo CYC_MUX. The test sweeps are those with index CYC_MUX/2-1 and CYC_MUX-1.
- R4: At the end of sweep CYC_MUX-1, a key is new if it was pressed in both tests of this cycle and not pressed in both tests of the previous cycle. New keys are ORed into key_deb, and key_deb changes at no other time except a clear.
- R5: A key held down through several cycles is reported only once. After one cycle seen released, it can be reported again.
- R6: A rd_clr cycle clears key_deb and irq_flag on the next edge. New keys found on that same edge are still stored, and irq_flag is set whenever new keys are stored.
- R7: Keys on ret_n[0] take part only when port_cfg[0]=1, and keys on ret_n[1] only when port_cfg[1]=1. Keys that do not take part read as not pressed.
- R8: Keys of digits above scan_lim read as not pressed and are never reported.
- R9: port_cfg[4:2] selects the pin. With 000, pin_lvl=0. With 001, pin_lvl=1. With 010, pin_lvl=~irq_flag. With 011, pin_lvl=irq_flag. With 1xx, pin_seg=1 and pin_lvl=0. pin_seg is 0 in every other mode.
- R10: port_rd = {port_cfg[4:0], ret_n[1], ret_n[0], irq_flag}.
- R11: A key seen pressed in only one of the two tests of a cycle is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_vld | input | 1 | One-cycle strobe: sample the current digit slot |
| dig_idx | input | 2 | Digit slot now driven |
| scan_lim | input | 2 | Highest enabled digit |
| ret_n | input | 2 | Active-low key return lines |
| port_cfg | input | 5 | {pin function[2:0], return 1 enable, return 0 enable} |
| rd_clr | input | 1 | Read strobe of the debounced register; clears it |
| key_prs | output | 8 | Keys pressed in the latest test |
| key_deb | output | 8 | Accumulated debounced keys |
| irq_flag | output | 1 | Interrupt flag |
| pin_lvl | output | 1 | Logic level for the shared pin |
| pin_seg | output | 1 | Shared pin handed to the segment driver |
| port_rd | output | 8 | Port register readback |

## Verification
Every stored result becomes visible one edge after the slot strobe that closes a test sweep. key_prs follows the closing slot of sweep CYC_MUX/2-1 or CYC_MUX-1, and key_deb and irq_flag follow the closing slot of sweep CYC_MUX-1 or a rd_clr strobe. The bench drives its inputs on falling edges and reads outputs on the falling edge right after the closing strobe. It compares them against a sweep-indexed model it keeps itself and against hand-derived masks. pin_lvl, pin_seg and port_rd are combinational, so they are checked in the same half-cycle their inputs settle.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

   typedef enum logic [2:0] {
      PF_DRIVE_LO = 3'b000,
      PF_DRIVE_HI = 3'b001,
      PF_IRQ_LOW  = 3'b010,
      PF_IRQ_HIGH = 3'b011
   } pin_func_e;

   typedef struct packed {
      logic [2:0] func;
      logic       en_ret1;
      logic       en_ret0;
   } port_cfg_t;

   localparam int CFG_W = 5;

endpackage

// File: rtl/kscan_timer.sv
module kscan_timer #(
   parameter int N_DIG   = 4,
   parameter int CYC_MUX = 32,
   localparam int DW     = (N_DIG > 1) ? $clog2(N_DIG) : 1,
   localparam int IW     = $clog2(CYC_MUX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slot_vld,
   input  logic [DW-1:0] dig_idx,
   input  logic [DW-1:0] scan_lim,
   output logic          mux_end,
   output logic          test_a_end,
   output logic          test_b_end
);
   localparam int HALF = CYC_MUX / 2;

   generate
      if ((CYC_MUX % 2) != 0 || CYC_MUX < 2)
         $error("kscan_timer: CYC_MUX must be even and at least 2");
   endgenerate

   logic [IW-1:0] sweep_idx;

   assign mux_end    = slot_vld && (dig_idx == scan_lim);
   assign test_a_end = mux_end && (sweep_idx == IW'(HALF - 1));
   assign test_b_end = mux_end && (sweep_idx == IW'(CYC_MUX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sweep_idx <= '0;
      else if (mux_end) begin
         if (sweep_idx == IW'(CYC_MUX - 1))
            sweep_idx <= '0;
         else
            sweep_idx <= sweep_idx + 1'b1;
      end
   end

   AST_SWEEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sweep_idx) < CYC_MUX); // R3

endmodule

// File: rtl/kscan_sampler.sv
module kscan_sampler #(
   parameter int N_DIG = 4,
   parameter int N_RET = 2,
   localparam int DW   = (N_DIG > 1) ? $clog2(N_DIG) : 1,
   localparam int NK   = N_DIG * N_RET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_vld,
   input  logic [DW-1:0]    dig_idx,
   input  logic [DW-1:0]    scan_lim,
   input  logic [N_RET-1:0] ret_n,
   input  logic [N_RET-1:0] ret_en,
   output logic [NK-1:0]    samp_nx,
   output logic [NK-1:0]    key_mask
);
   logic [NK-1:0] samp_q;

   always_comb begin
      samp_nx = samp_q;
      if (slot_vld && (int'(dig_idx) < N_DIG)) begin
         for (int r = 0; r < N_RET; r++)
            samp_nx[r*N_DIG + int'(dig_idx)] = ~ret_n[r];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         samp_q <= '0;
      else
         samp_q <= samp_nx;
   end

   for (genvar r = 0; r < N_RET; r++) begin : g_ret
      for (genvar d = 0; d < N_DIG; d++) begin : g_dig
         assign key_mask[r*N_DIG + d] = ret_en[r] && (d <= int'(scan_lim));
      end
   end

endmodule

// File: rtl/kscan_debounce.sv
module kscan_debounce #(
   parameter int NK = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NK-1:0] samp_nx,
   input  logic [NK-1:0] key_mask,
   input  logic          test_a_end,
   input  logic          test_b_end,
   input  logic          rd_clr,
   output logic [NK-1:0] key_prs,
   output logic [NK-1:0] key_deb,
   output logic          irq_flag
);
   logic [NK-1:0] test_a_q;
   logic [NK-1:0] held_q;
   logic [NK-1:0] seen_now;
   logic [NK-1:0] fresh;
   logic [NK-1:0] both_tests;

   assign seen_now   = samp_nx & key_mask;
   assign both_tests = test_a_q & seen_now;
   assign fresh      = test_b_end ? (both_tests & ~held_q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_a_q <= '0;
         held_q   <= '0;
         key_prs  <= '0;
         key_deb  <= '0;
         irq_flag <= 1'b0;
      end else begin
         if (test_a_end) begin
            test_a_q <= seen_now;
            key_prs  <= seen_now;
         end
         if (test_b_end) begin
            held_q  <= both_tests;
            key_prs <= seen_now;
         end
         key_deb  <= (rd_clr ? '0 : key_deb) | fresh;
         irq_flag <= (rd_clr ? 1'b0 : irq_flag) | (|fresh);
      end
   end

   AST_PRS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_a_end || test_b_end) |=> $stable(key_prs)); // R2
   AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && !test_b_end) |=> $stable(key_deb)); // R4
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !test_b_end) |=> (key_deb == '0 && !irq_flag)); // R6
   AST_IRQ_HAS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag |-> (key_deb != '0)); // R6
   AST_PRS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (test_a_end || test_b_end) |=> ((key_prs & ~$past(key_mask)) == '0)); // R8

endmodule

// File: rtl/kscan_pin.sv
module kscan_pin
   import kscan_pkg::*;
#(
   parameter int N_RET = 2
) (
   input  port_cfg_t        cfg,
   input  logic             irq_flag,
   input  logic [N_RET-1:0] ret_n,
   output logic             pin_lvl,
   output logic             pin_seg,
   output logic [7:0]       port_rd
);
   always_comb begin
      pin_seg = 1'b0;
      pin_lvl = 1'b0;
      if (cfg.func[2]) begin
         pin_seg = 1'b1;
      end else begin
         case (pin_func_e'(cfg.func))
            PF_DRIVE_LO: pin_lvl = 1'b0;
            PF_DRIVE_HI: pin_lvl = 1'b1;
            PF_IRQ_LOW:  pin_lvl = ~irq_flag;
            PF_IRQ_HIGH: pin_lvl = irq_flag;
            default:     pin_lvl = 1'b0;
         endcase
      end
   end

   assign port_rd = {cfg, ret_n[1], ret_n[0], irq_flag};

endmodule

// File: rtl/kscan_top.sv
module kscan_top
   import kscan_pkg::*;
#(
   parameter int N_DIG   = 4,
   parameter int N_RET   = 2,
   parameter int CYC_MUX = 32,
   localparam int DW     = (N_DIG > 1) ? $clog2(N_DIG) : 1,
   localparam int NK     = N_DIG * N_RET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_vld,
   input  logic [DW-1:0]    dig_idx,
   input  logic [DW-1:0]    scan_lim,
   input  logic [N_RET-1:0] ret_n,
   input  logic [CFG_W-1:0] port_cfg,
   input  logic             rd_clr,
   output logic [NK-1:0]    key_prs,
   output logic [NK-1:0]    key_deb,
   output logic             irq_flag,
   output logic             pin_lvl,
   output logic             pin_seg,
   output logic [7:0]       port_rd
);
   generate
      if (N_RET != 2)
         $error("kscan_top: port register layout needs exactly two returns");
      if (N_DIG < 2)
         $error("kscan_top: N_DIG must be at least 2");
   endgenerate

   port_cfg_t     cfg;
   logic          mux_end;
   logic          test_a_end;
   logic          test_b_end;
   logic [NK-1:0] samp_nx;
   logic [NK-1:0] key_mask;

   assign cfg = port_cfg_t'(port_cfg);

   kscan_timer #(.N_DIG(N_DIG), .CYC_MUX(CYC_MUX)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_vld   (slot_vld),
      .dig_idx    (dig_idx),
      .scan_lim   (scan_lim),
      .mux_end    (mux_end),
      .test_a_end (test_a_end),
      .test_b_end (test_b_end)
   );

   kscan_sampler #(.N_DIG(N_DIG), .N_RET(N_RET)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_vld (slot_vld),
      .dig_idx  (dig_idx),
      .scan_lim (scan_lim),
      .ret_n    (ret_n),
      .ret_en   ({cfg.en_ret1, cfg.en_ret0}),
      .samp_nx  (samp_nx),
      .key_mask (key_mask)
   );

   kscan_debounce #(.NK(NK)) u_deb (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_nx    (samp_nx),
      .key_mask   (key_mask),
      .test_a_end (test_a_end),
      .test_b_end (test_b_end),
      .rd_clr     (rd_clr),
      .key_prs    (key_prs),
      .key_deb    (key_deb),
      .irq_flag   (irq_flag)
   );

   kscan_pin #(.N_RET(N_RET)) u_pin (
      .cfg      (cfg),
      .irq_flag (irq_flag),
      .ret_n    (ret_n),
      .pin_lvl  (pin_lvl),
      .pin_seg  (pin_seg),
      .port_rd  (port_rd)
   );

   AST_TEST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_a_end && test_b_end)); // R3
   AST_SEG_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      pin_seg |-> (port_rd[7] && !pin_lvl)); // R9

endmodule

// File: tb/kscan_top_tb.sv
module kscan_top_tb;
   localparam int CYC  = 4;
   localparam int HALF = CYC / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_vld = 1'b0;
   logic [1:0] dig_idx = '0;
   logic [1:0] scan_lim = 2'd3;
   logic [1:0] ret_n = 2'b11;
   logic [4:0] port_cfg = 5'b010_11;
   logic       rd_clr = 1'b0;
   logic [7:0] key_prs, key_deb, port_rd;
   logic       irq_flag, pin_lvl, pin_seg;

   int n_run = 0;
   int n_fail = 0;

   logic [7:0] keys = '0;
   int         bmux = 0;
   logic [7:0] bta = '0, bprev = '0, bdeb = '0, bprs = '0;
   logic       birq = 1'b0;

   always #2.5 clk = ~clk;

   kscan_top #(.N_DIG(4), .N_RET(2), .CYC_MUX(CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .dig_idx(dig_idx),
      .scan_lim(scan_lim), .ret_n(ret_n), .port_cfg(port_cfg), .rd_clr(rd_clr),
      .key_prs(key_prs), .key_deb(key_deb), .irq_flag(irq_flag),
      .pin_lvl(pin_lvl), .pin_seg(pin_seg), .port_rd(port_rd)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mask_of(input logic [1:0] en, input logic [1:0] lim);
      logic [7:0] m = '0;
      for (int d = 0; d < 4; d++) begin
         if (d <= int'(lim)) begin
            if (en[0]) m[d] = 1'b1;
            if (en[1]) m[d+4] = 1'b1;
         end
      end
      return m;
   endfunction

   // One multiplex sweep over digits 0..scan_lim; optional clear on the last slot.
   task automatic run_mux(input bit clr_last);
      logic [7:0] s, nw;
      for (int d = 0; d <= int'(scan_lim); d++) begin
         @(negedge clk);
         dig_idx  = 2'(d);
         ret_n    = {~keys[d+4], ~keys[d]};
         slot_vld = 1'b1;
         rd_clr   = clr_last && (d == int'(scan_lim));
      end
      @(negedge clk);
      slot_vld = 1'b0;
      rd_clr   = 1'b0;
      ret_n    = 2'b11;
      s = keys & mask_of(port_cfg[1:0], scan_lim);
      if (clr_last) begin bdeb = '0; birq = 1'b0; end
      if (bmux == HALF-1) begin bta = s; bprs = s; end
      if (bmux == CYC-1) begin
         bprs  = s;
         nw    = bta & s & ~bprev;
         bprev = bta & s;
         bdeb  = bdeb | nw;
         birq  = birq | (nw != 0);
      end
      bmux = (bmux + 1) % CYC;
      chk("R2 key_prs", key_prs, bprs);
      chk("R4 key_deb", key_deb, bdeb);
      chk("R6 irq_flag", {7'd0, irq_flag}, {7'd0, birq});
   endtask

   task automatic run_cycle();
      for (int i = 0; i < CYC; i++) run_mux(1'b0);
   endtask

   task automatic do_clear();
      @(negedge clk);
      rd_clr = 1'b1;
      @(negedge clk);
      rd_clr = 1'b0;
      bdeb = '0; birq = 1'b0;
      chk("R6 cleared key_deb", key_deb, 8'h00);
      chk("R6 cleared irq", {7'd0, irq_flag}, 8'h00);
   endtask

   // Release everything for a full cycle so no key is held over, then clear.
   task automatic settle();
      keys = '0;
      while (bmux != 0) run_mux(1'b0);
      run_cycle();
      do_clear();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 key_prs", key_prs, 8'h00);
      chk("R1 key_deb", key_deb, 8'h00);
      chk("R1 irq", {7'd0, irq_flag}, 8'h00);

      // R2 R3 R4: each key alone, full cycle
      for (int k = 0; k < 8; k++) begin
         keys = 8'(1 << k);
         run_cycle();
         chk("R4 single key reported", key_deb, 8'(1 << k));
         chk("R9 active-low irq pin", {7'd0, pin_lvl}, 8'h00);
         settle();
         chk("R9 irq pin idle", {7'd0, pin_lvl}, 8'h01);
      end

      // R5 held key reports once
      keys = 8'h05;
      run_cycle();
      chk("R5 first report", key_deb, 8'h05);
      do_clear();
      run_cycle();
      run_cycle();
      chk("R5 held not reported again", key_deb, 8'h00);
      chk("R5 held still pressed", key_prs, 8'h05);
      keys = '0;
      run_cycle();
      keys = 8'h05;
      run_cycle();
      chk("R5 re-press reported", key_deb, 8'h05);
      settle();

      // R11 pressed in one test only
      keys = 8'h80;
      run_mux(1'b0); run_mux(1'b0);
      chk("R11 first test sees key", key_prs, 8'h80);
      keys = '0;
      run_mux(1'b0); run_mux(1'b0);
      chk("R11 first-test-only ignored", key_deb, 8'h00);
      run_mux(1'b0); run_mux(1'b0);
      keys = 8'h40;
      run_mux(1'b0); run_mux(1'b0);
      chk("R11 second-test-only ignored", key_deb, 8'h00);
      settle();

      // R7 R8: sweep scan limit and return enables with all keys down
      for (int lim = 0; lim < 4; lim++) begin
         for (int en = 0; en < 4; en++) begin
            scan_lim = 2'(lim);
            port_cfg = {3'b010, 2'(en)};
            settle();
            keys = 8'hFF;
            run_cycle();
            chk("R7 R8 masked report", key_deb, mask_of(2'(en), 2'(lim)));
            chk("R8 masked pressed", key_prs, mask_of(2'(en), 2'(lim)));
         end
      end
      scan_lim = 2'd3;
      port_cfg = 5'b010_11;
      settle();

      // R6 clear on the same edge as new keys
      keys = 8'h0F;
      for (int i = 0; i < CYC-1; i++) run_mux(1'b0);
      run_mux(1'b1);
      chk("R6 same-edge keys kept", key_deb, 8'h0F);
      chk("R6 same-edge irq set", {7'd0, irq_flag}, 8'h01);

      // R9 R10 pin function and readback, irq set then clear
      for (int ph = 0; ph < 2; ph++) begin
         for (int f = 0; f < 8; f++) begin
            logic exp_lvl;
            @(negedge clk);
            port_cfg = {3'(f), 2'b11};
            ret_n = 2'(f % 4);
            #1;
            case (f)
               0: exp_lvl = 1'b0;
               1: exp_lvl = 1'b1;
               2: exp_lvl = ~birq;
               3: exp_lvl = birq;
               default: exp_lvl = 1'b0;
            endcase
            chk("R9 pin_lvl", {7'd0, pin_lvl}, {7'd0, exp_lvl});
            chk("R9 pin_seg", {7'd0, pin_seg}, {7'd0, f >= 4});
            chk("R10 port_rd", port_rd, {3'(f), 2'b11, 2'(f % 4), birq});
         end
         ret_n = 2'b11;
         port_cfg = 5'b010_11;
         if (ph == 0) do_clear();
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule